// File: doc/BRIEF.md
# Page Load Buffer with Inactivity Close

This block gathers the words of one page-program operation before a programming engine writes them into the array. Each word arrives as a load strobe. The strobe's assertion carries a 20-bit word address, and its release carries a data word. The upper address bits name the page and the lower six name the slot within the 64-word page. Slots may be filled in any order, and a slot written twice keeps the last value. Loads that name a different page from the one that opened the period are dropped and reported on an error pulse.

No command ends a load period. The period closes on its own in one of two ways:
- no new strobe follows the last completed load within a timeout measured in clock cycles;
- the 64th load has been accepted.

On close the block issues a one-cycle start pulse together with the page number and a mask of the slots that were loaded. The engine reads the buffer through a read port with one cycle of latency. Slots that were never loaded read back as all ones, which is the erased value. The buffer ignores every strobe until the engine answers with a done pulse.

Top module: `page_load_buffer`

## Requirements
- R1: After reset, `pgm_start` and `ld_err` are low and `pgm_mask` is all zero.
- R2: A load's page is `ld_addr[19:6]` and its slot is `ld_addr[5:0]`, both sampled on the clock edge where `ld_act` is first seen high. Its data is `ld_data`, sampled on the edge where `ld_act` is first seen low again. That data is stored in that slot and mask bit `slot` is set.
- R3: Loads within one period may target the slots in any order, and each slot keeps its own data.
- R4: After a period closes, every slot whose mask bit is 0 reads back as all ones on `rd_data`.
- R5: While a period is open, a timer restarts at each completed, accepted load and stands still while `ld_act` is high. If it then runs `TO_CYC` cycles with no strobe (50 MHz × 100 µs = 5000 by default), `pgm_start` is high in the cycle after the edge that is `TO_CYC` edges past the completing edge. At that point `pgm_page` and `pgm_mask` describe the period.
- R6: `pgm_start` is high for exactly one cycle per closed period.
- R7: A load whose page differs from the page of the period's first load is discarded: no data, no mask bit, no timer restart. `ld_err` is high for one cycle, starting in the cycle after the edge where that strobe was first seen high. For accepted loads `ld_err` stays low.
- R8: The completing edge of the 64th accepted load of a period closes the period at once. `pgm_start` is high in the cycle right after that edge.
- R9: From `pgm_start` until `pgm_done`, strobes are ignored. `pgm_mask`, `pgm_page` and the stored data stay unchanged, and no further `pgm_start` is issued.
- R10: `rd_data` shows the slot named by `rd_idx` one clock edge after `rd_idx` is sampled.
- R11: The first load after `pgm_done` opens a new period. The mask is cleared and the page is taken from that load, so slots loaded only in earlier periods read as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_act | input | 1 | Load strobe, high while a word load is in progress |
| ld_addr | input | 20 | Word address, sampled when the strobe rises |
| ld_data | input | 16 | Data word, sampled when the strobe falls |
| ld_err | output | 1 | One-cycle pulse: load discarded for a page mismatch |
| rd_idx | input | 6 | Slot to read |
| rd_data | output | 16 | Slot contents, all ones if not loaded |
| pgm_start | output | 1 | One-cycle pulse: load period closed |
| pgm_page | output | 14 | Page number of the closed period |
| pgm_mask | output | 64 | Bit i set when slot i was loaded |
| pgm_done | input | 1 | Engine finished, buffer may reopen |

## Verification
Strobe edges are driven at falling clock edges, so the design sees each one at the next rising edge. The bench records that edge's cycle number for every completed load.

A timeout close is due exactly `TO_CYC` cycles after the completing edge. A 64th-load close is due in the same cycle as the completing edge is seen. The driver queues the expected cycle, page and mask, and a monitor compares them against every `pgm_start` it observes.

`ld_err` is checked one cycle after the strobe rise. Read data is checked one cycle after `rd_idx` is set. All samples are taken at falling edges.

// File: rtl/plb_pkg.sv
package plb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2
  } plb_state_e;
endpackage

// File: rtl/plb_edge.sv
// Strobe edge detector: one register of history, edges decoded against the live input.
module plb_edge (
  input  logic clk,
  input  logic rst,
  input  logic act,
  output logic rise,
  output logic fall
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  assign rise = act & ~act_q;
  assign fall = ~act & act_q;
endmodule

// File: rtl/plb_timer.sv
// Inactivity timer: cleared when idle or restarted, frozen while held.
module plb_timer #(
  parameter int LIMIT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold,
  input  logic restart,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (!hold && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = run && !hold && !restart && (cnt == LAST);
endmodule

// File: rtl/plb_store.sv
// Page storage: unreset RAM (block RAM friendly) plus a resettable loaded mask.
module plb_store #(
  parameter int DATA_W = 16,
  parameter int OFF_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    we,
  input  logic [OFF_W-1:0]        waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [OFF_W-1:0]        raddr,
  output logic [DATA_W-1:0]       rdata,
  output logic [(1<<OFF_W)-1:0]   mask
);
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic              hit_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      mask <= '0;
    end else if (we) begin
      mask[waddr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= mask[raddr];
  end

  assign rdata = hit_q ? mem_q : {DATA_W{1'b1}};
endmodule

// File: rtl/page_load_buffer.sv
module page_load_buffer #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int OFF_W      = 6,
  parameter int CLK_HZ     = 50_000_000,
  parameter int TIMEOUT_US = 100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_act,
  input  logic [ADDR_W-1:0]        ld_addr,
  input  logic [DATA_W-1:0]        ld_data,
  output logic                     ld_err,
  input  logic [OFF_W-1:0]         rd_idx,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     pgm_start,
  output logic [ADDR_W-OFF_W-1:0]  pgm_page,
  output logic [(1<<OFF_W)-1:0]    pgm_mask,
  input  logic                     pgm_done
);
  import plb_pkg::*;

  localparam int DEPTH  = 1 << OFF_W;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int TO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int LCNT_W = OFF_W + 1;
  localparam logic [LCNT_W-1:0] LCNT_LAST = LCNT_W'(DEPTH - 1);

  plb_state_e         state;
  logic [PAGE_W-1:0]  page_r;
  logic [OFF_W-1:0]   off_r;
  logic               cur_ok;
  logic [LCNT_W-1:0]  lcnt;
  logic               start_q;
  logic               err_q;

  logic               rise, fall;
  logic               acc_fall;
  logic               expire;
  logic               close;
  logic               clear;
  logic [PAGE_W-1:0]  in_page;
  logic [OFF_W-1:0]   in_off;

  assign in_page = ld_addr[ADDR_W-1:OFF_W];
  assign in_off  = ld_addr[OFF_W-1:0];

  plb_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .act  (ld_act),
    .rise (rise),
    .fall (fall)
  );

  assign acc_fall = fall && cur_ok && (state == ST_LOAD);
  assign clear    = rise && (state == ST_IDLE);

  plb_timer #(.LIMIT(TO_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_LOAD),
    .hold    (ld_act),
    .restart (acc_fall),
    .expire  (expire)
  );

  assign close = (state == ST_LOAD) &&
                 (expire || (acc_fall && lcnt == LCNT_LAST));

  plb_store #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clear (clear),
    .we    (acc_fall),
    .waddr (off_r),
    .wdata (ld_data),
    .raddr (rd_idx),
    .rdata (rd_data),
    .mask  (pgm_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      page_r  <= '0;
      off_r   <= '0;
      cur_ok  <= 1'b0;
      lcnt    <= '0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (rise) begin
            page_r <= in_page;
            off_r  <= in_off;
            cur_ok <= 1'b1;
            lcnt   <= '0;
            state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (rise) begin
            if (in_page == page_r) begin
              off_r  <= in_off;
              cur_ok <= 1'b1;
            end else begin
              cur_ok <= 1'b0;
              err_q  <= 1'b1;
            end
          end
          if (acc_fall) lcnt <= lcnt + 1'b1;
          if (close) begin
            state   <= ST_WAIT;
            start_q <= 1'b1;
            cur_ok  <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (pgm_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pgm_start = start_q;
  assign ld_err    = err_q;
  assign pgm_page  = page_r;
endmodule

// File: rtl/plb_chk.sv
module plb_chk #(
  parameter int PAGE_W = 14,
  parameter int DEPTH  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_act,
  input logic              ld_err,
  input logic              pgm_start,
  input logic [PAGE_W-1:0] pgm_page,
  input logic [DEPTH-1:0]  pgm_mask,
  input logic              pgm_done
);
  logic wait_q;

  always_ff @(posedge clk) begin
    if (rst)            wait_q <= 1'b0;
    else if (pgm_start) wait_q <= 1'b1;
    else if (pgm_done)  wait_q <= 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!pgm_start && !ld_err && pgm_mask == '0)); // R1

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pgm_start |=> !pgm_start); // R6

  AST_START_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
    pgm_start |-> (pgm_mask != '0)); // R5

  AST_ERR_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    ld_err |-> $past(ld_act)); // R7

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ld_err |=> !ld_err); // R7

  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (wait_q && !pgm_done) |=> ($stable(pgm_mask) && $stable(pgm_page))); // R9

  AST_NO_START_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    wait_q |-> !pgm_start); // R9
endmodule

bind page_load_buffer plb_chk #(.PAGE_W(PAGE_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_act    (ld_act),
  .ld_err    (ld_err),
  .pgm_start (pgm_start),
  .pgm_page  (pgm_page),
  .pgm_mask  (pgm_mask),
  .pgm_done  (pgm_done)
);

// File: tb/page_load_buffer_tb.sv
module page_load_buffer_tb;
  localparam int TO = (50_000_000 / 1_000_000) * 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_act = 1'b0;
  logic [19:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        ld_err;
  logic [5:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        pgm_start;
  logic [13:0] pgm_page;
  logic [63:0] pgm_mask;
  logic        pgm_done = 1'b0;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int nstart = 0;
  bit finished = 1'b0;

  typedef struct {
    int          at;
    logic [13:0] page;
    logic [63:0] mask;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  page_load_buffer u_dut (
    .clk(clk), .rst(rst), .ld_act(ld_act), .ld_addr(ld_addr), .ld_data(ld_data),
    .ld_err(ld_err), .rd_idx(rd_idx), .rd_data(rd_data), .pgm_start(pgm_start),
    .pgm_page(pgm_page), .pgm_mask(pgm_mask), .pgm_done(pgm_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every start pulse.
  always @(negedge clk) begin
    if (!rst && pgm_start) begin
      nstart++;
      if (sb.size() == 0) begin
        chk(1'b0, "R6", "unexpected pgm_start", 64'(cyc), 64'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.at, "R5", "start cycle", 64'(cyc), 64'(e.at));
        chk(pgm_page == e.page, "R2", "pgm_page", 64'(pgm_page), 64'(e.page));
        chk(pgm_mask == e.mask, "R3", "pgm_mask", pgm_mask, e.mask);
      end
    end
  end

  task automatic do_load(input logic [19:0] a, input logic [15:0] d, input int hold,
                         input bit exp_err, input string req, output int fall_at);
    @(negedge clk);
    ld_addr = a;
    ld_act  = 1'b1;
    @(negedge clk);
    chk(ld_err == exp_err, req, "ld_err after strobe rise", 64'(ld_err), 64'(exp_err));
    for (int i = 1; i < hold; i++) @(negedge clk);
    ld_data = d;
    ld_act  = 1'b0;
    fall_at = cyc + 1;
  endtask

  task automatic rd(input logic [5:0] idx, input logic [15:0] exp, input string req);
    @(negedge clk);
    rd_idx = idx;
    @(negedge clk);
    chk(rd_data == exp, req, "rd_data", 64'(rd_data), 64'(exp));
  endtask

  task automatic wait_start();
    int n0;
    n0 = nstart;
    while (nstart == n0) @(negedge clk);
  endtask

  task automatic done_pulse();
    @(negedge clk);
    pgm_done = 1'b1;
    @(negedge clk);
    pgm_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int f;
    exp_t e;
    logic [63:0] m;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!pgm_start, "R1", "pgm_start after reset", 64'(pgm_start), 64'(0));
    chk(!ld_err, "R1", "ld_err after reset", 64'(ld_err), 64'(0));
    chk(pgm_mask == '0, "R1", "pgm_mask after reset", pgm_mask, 64'(0));

    // Period A: out-of-order loads, a foreign-page load, close by timeout (R2 R3 R5 R7)
    do_load({14'h1A3, 6'd5},  16'h5555, 2, 1'b0, "R2", f);
    do_load({14'h1A3, 6'd0},  16'h0A0A, 1, 1'b0, "R3", f);
    do_load({14'h0A3, 6'd7},  16'h7777, 3, 1'b1, "R7", f);
    do_load({14'h1A3, 6'd63}, 16'hC3C3, 1, 1'b0, "R3", f);
    m = (64'd1 << 5) | 64'd1 | (64'd1 << 63);
    e.at = f + TO; e.page = 14'h1A3; e.mask = m;
    sb.push_back(e);
    wait_start();
    rd(6'd5,  16'h5555, "R2");
    rd(6'd0,  16'h0A0A, "R3");
    rd(6'd63, 16'hC3C3, "R10");
    rd(6'd1,  16'hFFFF, "R4");
    rd(6'd7,  16'hFFFF, "R7");

    // R9: loads while waiting for done are ignored
    do_load({14'h1A3, 6'd1}, 16'h1234, 2, 1'b0, "R9", f);
    repeat (4) @(negedge clk);
    chk(pgm_mask == m, "R9", "mask frozen while waiting", pgm_mask, m);
    rd(6'd1, 16'hFFFF, "R9");
    rd(6'd5, 16'h5555, "R9");
    done_pulse();

    // Period B: 64 loads in a permuted order close at once (R8)
    for (int i = 0; i < 64; i++) begin
      do_load({14'h3FFF, 6'((i * 37) % 64)}, 16'h8000 ^ 16'(i), 1, 1'b0, "R8", f);
    end
    e.at = f; e.page = 14'h3FFF; e.mask = '1;
    sb.push_back(e);
    wait_start();
    rd(6'd0,  16'h8000, "R8");
    rd(6'd37, 16'h8001, "R8");
    done_pulse();

    // Period C: new period clears the old mask (R11)
    do_load({14'h0001, 6'd10}, 16'hBEEF, 1, 1'b0, "R11", f);
    e.at = f + TO; e.page = 14'h0001; e.mask = 64'd1 << 10;
    sb.push_back(e);
    wait_start();
    rd(6'd10, 16'hBEEF, "R11");
    rd(6'd0,  16'hFFFF, "R11");
    done_pulse();

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R5", "pending expected starts", 64'(sb.size()), 64'(0));
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule